// File: doc/BRIEF.md
# Multi-mode operand address generator

This block forms the effective address of a load-type operand for one of ten addressing modes, fetches the operand through a simple synchronous memory read port, and returns it with a register write-back value for the modes that modify their base register. A caller presents a mode code, base and index register values, a 16-bit displacement, a 2-bit scale selector, a PC value and a PC-as-base select, then pulses `start`. The block answers with a one-cycle `done` pulse that carries the operand. If the mode is one of the three updating modes, `done` also carries a write-back strobe and value.

The memory port is a request/address pair. The memory samples it on a clock edge and returns the read word on `mem_rdata` during the following cycle. Memory-indirect mode chains two dependent reads: the word from the first read becomes the address of the second. A small sequencer therefore owns the handshake and holds the block busy until the last read returns. Address arithmetic wraps modulo 2^32. The displacement is sign-extended to 32 bits.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (constant) returns the sign-extended displacement as the operand with `done` one cycle after `start` is sampled, and makes no memory request.
- R2: Mode code 1 (register) returns `base_val` as the operand with `done` one cycle after `start` is sampled, and makes no memory request.
- R3: Mode code 2 reads at `base_val`. Mode code 3 reads at base plus sign-extended displacement, where the base is `pc_val` when `pc_sel` is 1 and `base_val` otherwise. The sum wraps modulo 2^32.
- R4: Mode code 4 reads at `base_val + index_val`. Mode code 5 reads at `base_val + (index_val << scale)` for scale 0 to 3, which gives factors 1, 2, 4 and 8.
- R5: Mode codes 6 (post-increment) and 7 (post-decrement) read at `base_val` and write back `base_val + (1 << scale)` or `base_val - (1 << scale)` respectively.
- R6: Mode code 8 (update) reads at `base_val` plus sign-extended displacement and writes that same address back.
- R7: Mode code 9 (indirect) reads at `base_val`, then reads again at the returned word. The operand is the second read's data.
- R8: The memory returns data the cycle after a sampled request. Single-read modes pulse `done` two cycles after `start` is sampled, and mode 9 pulses it three cycles after. Each operation raises `done` exactly once.
- R9: `wb_en` is high only together with `done`, and only for mode codes 6, 7 and 8.
- R10: Mode codes 10 to 15 raise `illegal` together with `done` for one cycle, with no memory request and no write-back.
- R11: A `start` received while an operation is in progress is ignored. It causes no extra `done` and no extra memory request, and it does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| mode | input | 4 | Addressing mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp | input | 16 | Displacement / constant field, sign-extended |
| scale | input | 2 | Shift amount for scaled index and step size |
| pc_val | input | 32 | Current PC |
| pc_sel | input | 1 | Use PC as base in mode 3 |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after a request |
| done | output | 1 | Operation complete pulse |
| operand | output | 32 | Fetched or direct operand, valid with `done` |
| wb_en | output | 1 | Base register write-back strobe |
| wb_data | output | 32 | Base register write-back value |
| illegal | output | 1 | Undefined mode code pulse |

## Verification
A bench memory returns a scrambled function of the address, so every returned operand also proves which address was read. Displacement tests use positive and negative values and a value that wraps past zero. Running mode 3 with and without the PC select separates the PC base from the register base. Scaled index is run at all four scales to tell each shift amount apart, and the two stepping modes use different scales to tell the step size from the sign. The indirect mode, the illegal codes and a `start` sent while busy are judged by how many memory requests are counted, by the done latency and by the operand.

// File: rtl/opaddr_pkg.sv
// Shared mode and sequencer state types for the operand address generator.
package opaddr_pkg;
    typedef enum logic [3:0] {
        M_CONST  = 4'd0,
        M_REG    = 4'd1,
        M_RIND   = 4'd2,
        M_BDISP  = 4'd3,
        M_BIDX   = 4'd4,
        M_SCALED = 4'd5,
        M_POSTINC= 4'd6,
        M_POSTDEC= 4'd7,
        M_UPDATE = 4'd8,
        M_INDIR  = 4'd9
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD1  = 2'd1,
        S_RD2  = 2'd2
    } seq_e;
endpackage

// File: rtl/opaddr_calc.sv
// Combinational address and write-back value former.
// Decodes the mode into class flags and computes the first read address,
// the direct operand and the base update value. Assumes DW >= DSPW.
module opaddr_calc
    import opaddr_pkg::*;
#(
    parameter int DW   = 32,
    parameter int DSPW = 16,
    parameter int SCW  = 2
) (
    input  logic [3:0]      mode,
    input  logic [DW-1:0]   base_val,
    input  logic [DW-1:0]   index_val,
    input  logic [DSPW-1:0] disp,
    input  logic [SCW-1:0]  scale,
    input  logic [DW-1:0]   pc_val,
    input  logic            pc_sel,
    output logic            legal,
    output logic            is_mem,
    output logic            is_ind,
    output logic            is_wb,
    output logic [DW-1:0]   addr,
    output logic [DW-1:0]   direct,
    output logic [DW-1:0]   wb_val
);
    localparam int EXTW = DW - DSPW;

    logic [DW-1:0] sdisp;
    logic [DW-1:0] step;
    logic [DW-1:0] disp_base;
    mode_e         m;

    assign sdisp     = {{EXTW{disp[DSPW-1]}}, disp};
    assign step      = DW'(1) << scale;
    assign disp_base = pc_sel ? pc_val : base_val;
    assign m         = mode_e'(mode);

    // Decode mode into address, direct operand and update value.
    always_comb begin
        legal  = 1'b1;
        is_mem = 1'b1;
        is_ind = 1'b0;
        is_wb  = 1'b0;
        addr   = base_val;
        direct = base_val;
        wb_val = base_val;
        case (m)
            M_CONST:   begin is_mem = 1'b0; direct = sdisp; end
            M_REG:     begin is_mem = 1'b0; end
            M_RIND:    addr = base_val;
            M_BDISP:   addr = disp_base + sdisp;
            M_BIDX:    addr = base_val + index_val;
            M_SCALED:  addr = base_val + (index_val << scale);
            M_POSTINC: begin is_wb = 1'b1; wb_val = base_val + step; end
            M_POSTDEC: begin is_wb = 1'b1; wb_val = base_val - step; end
            M_UPDATE:  begin is_wb = 1'b1; addr = base_val + sdisp; wb_val = base_val + sdisp; end
            M_INDIR:   is_ind = 1'b1;
            default:   begin legal = 1'b0; is_mem = 1'b0; end
        endcase
    end
endmodule

// File: rtl/opaddr_seq.sv
// Handshake and read sequencer.
// Accepts a start only while idle, issues one or two dependent reads and
// registers the result into a one-cycle done pulse. Assumes the memory
// returns data the cycle after it samples a request.
module opaddr_seq
    import opaddr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          legal,
    input  logic          is_mem,
    input  logic          is_ind,
    input  logic          is_wb,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] direct,
    input  logic [DW-1:0] wb_val,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    output logic          done,
    output logic [DW-1:0] operand,
    output logic          wb_en,
    output logic [DW-1:0] wb_data,
    output logic          illegal,
    output logic          busy
);
    seq_e          state_q;
    logic          ind_q;
    logic          wb_q;
    logic [DW-1:0] wbv_q;
    logic          accept;

    assign accept = start && (state_q == S_IDLE);
    assign busy   = (state_q != S_IDLE);

    // Drive the read port: first read from the calculator, second from memory.
    always_comb begin
        mem_req  = (accept && legal && is_mem) || ((state_q == S_RD1) && ind_q);
        mem_addr = (state_q == S_RD1) ? mem_rdata : addr;
    end

    // Advance the sequence and register the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ind_q   <= 1'b0;
            wb_q    <= 1'b0;
            wbv_q   <= '0;
            done    <= 1'b0;
            operand <= '0;
            wb_en   <= 1'b0;
            wb_data <= '0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            wb_en   <= 1'b0;
            illegal <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        if (!legal) begin
                            illegal <= 1'b1;
                            done    <= 1'b1;
                        end else if (!is_mem) begin
                            operand <= direct;
                            done    <= 1'b1;
                        end else begin
                            state_q <= S_RD1;
                            ind_q   <= is_ind;
                            wb_q    <= is_wb;
                            wbv_q   <= wb_val;
                        end
                    end
                end
                S_RD1: begin
                    if (ind_q) begin
                        state_q <= S_RD2;
                    end else begin
                        operand <= mem_rdata;
                        done    <= 1'b1;
                        wb_en   <= wb_q;
                        wb_data <= wbv_q;
                        state_q <= S_IDLE;
                    end
                end
                S_RD2: begin
                    operand <= mem_rdata;
                    done    <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/opaddr_gen.sv
// Multi-mode operand address generator top.
// Joins the address calculator and the read sequencer. Inputs are sampled
// on the edge where start is seen while idle; they need not be held.
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int DW   = 32,
    parameter int DSPW = 16,
    parameter int SCW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      mode,
    input  logic [DW-1:0]   base_val,
    input  logic [DW-1:0]   index_val,
    input  logic [DSPW-1:0] disp,
    input  logic [SCW-1:0]  scale,
    input  logic [DW-1:0]   pc_val,
    input  logic            pc_sel,
    output logic            mem_req,
    output logic [DW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            done,
    output logic [DW-1:0]   operand,
    output logic            wb_en,
    output logic [DW-1:0]   wb_data,
    output logic            illegal
);
    logic          legal, is_mem, is_ind, is_wb, busy;
    logic [DW-1:0] addr, direct, wb_val;

    opaddr_calc #(.DW(DW), .DSPW(DSPW), .SCW(SCW)) u_calc (
        .mode(mode), .base_val(base_val), .index_val(index_val),
        .disp(disp), .scale(scale), .pc_val(pc_val), .pc_sel(pc_sel),
        .legal(legal), .is_mem(is_mem), .is_ind(is_ind), .is_wb(is_wb),
        .addr(addr), .direct(direct), .wb_val(wb_val)
    );

    opaddr_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .legal(legal), .is_mem(is_mem), .is_ind(is_ind), .is_wb(is_wb),
        .addr(addr), .direct(direct), .wb_val(wb_val),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .done(done), .operand(operand), .wb_en(wb_en), .wb_data(wb_data),
        .illegal(illegal), .busy(busy)
    );
endmodule

// File: rtl/opaddr_chk.sv
// Protocol checker for opaddr_gen, attached by bind.
module opaddr_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic          busy,
    input logic          mem_req,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_rdata,
    input logic          done,
    input logic          wb_en,
    input logic          illegal
);
    assert_wb_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    assert_illegal_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !wb_en));

    assert_bad_code_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (mode > 4'd9)) |=> (illegal && done));

    assert_no_req_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |-> !mem_req);

    assert_chained_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (mode == 4'd9)) |=> (mem_req && (mem_addr == mem_rdata)));

    assert_busy_no_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req) |=> !done);
endmodule

bind opaddr_gen opaddr_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .wb_en(wb_en), .illegal(illegal)
);

// File: tb/tb_opaddr_gen.sv
// Directed bench for opaddr_gen with a scrambling synchronous memory model.
module tb_opaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] base_val = '0, index_val = '0, pc_val = '0;
    logic [15:0] disp = '0;
    logic [1:0]  scale = '0;
    logic        pc_sel = 1'b0;
    logic        mem_req, done, wb_en, illegal;
    logic [31:0] mem_addr, operand, wb_data;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int req_cnt = 0;
    logic [31:0] addr_log0, addr_log1;

    always #5 clk = ~clk;

    opaddr_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base_val(base_val), .index_val(index_val), .disp(disp),
        .scale(scale), .pc_val(pc_val), .pc_sel(pc_sel),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .operand(operand), .wb_en(wb_en), .wb_data(wb_data),
        .illegal(illegal)
    );

    function automatic logic [31:0] scram(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_1234;
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] d);
        return {{16{d[15]}}, d};
    endfunction

    // Memory model: returns scrambled address the cycle after a request.
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= scram(mem_addr);
            if (req_cnt == 0) addr_log0 <= mem_addr;
            if (req_cnt == 1) addr_log1 <= mem_addr;
            req_cnt <= req_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] r_opnd, r_wbd;
    logic        r_wbe, r_ill;
    int          r_lat;

    // Issue one operation and wait for done.
    task automatic run_op(input logic [3:0] m, input logic [31:0] b, input logic [31:0] ix,
                          input logic [15:0] d, input logic [1:0] sc, input logic ps,
                          input logic [31:0] pc);
        @(negedge clk);
        req_cnt = 0;
        mode = m; base_val = b; index_val = ix; disp = d; scale = sc;
        pc_sel = ps; pc_val = pc; start = 1'b1;
        r_lat = 0; r_opnd = 'x; r_wbe = 1'b0; r_wbd = 'x; r_ill = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            start = 1'b0;
            r_lat++;
            if (done) begin
                r_opnd = operand; r_wbe = wb_en; r_wbd = wb_data; r_ill = illegal;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R8 reset done", {31'b0, done}, 32'd0);
        chk("R9 reset wb_en", {31'b0, wb_en}, 32'd0);
        chk("R10 reset illegal", {31'b0, illegal}, 32'd0);
    endtask

    task automatic t_direct();
        run_op(4'd0, 32'h1111_0000, 0, 16'hFF80, 0, 0, 0);
        chk("R1 const operand", r_opnd, 32'hFFFF_FF80);
        chk("R1 const latency", r_lat, 1);
        chk("R1 const no read", req_cnt, 0);
        run_op(4'd1, 32'hCAFE_1234, 0, 16'h0005, 0, 0, 0);
        chk("R2 reg operand", r_opnd, 32'hCAFE_1234);
        chk("R2 reg latency", r_lat, 1);
        chk("R2 reg no read", req_cnt, 0);
        chk("R9 reg no wb", {31'b0, r_wbe}, 32'd0);
    endtask

    task automatic t_disp();
        run_op(4'd2, 32'h0000_4000, 0, 16'h0040, 0, 0, 0);
        chk("R3 rind addr", addr_log0, 32'h0000_4000);
        chk("R3 rind operand", r_opnd, scram(32'h0000_4000));
        chk("R8 single latency", r_lat, 2);
        run_op(4'd3, 32'h0000_4000, 0, 16'hFFF0, 0, 0, 32'h8000_0000);
        chk("R3 bdisp neg", addr_log0, 32'h0000_3FF0);
        run_op(4'd3, 32'h0000_4000, 0, 16'h0100, 0, 1, 32'h8000_0010);
        chk("R3 pc relative", addr_log0, 32'h8000_0110);
        chk("R3 pc operand", r_opnd, scram(32'h8000_0110));
        run_op(4'd3, 32'h0000_0008, 0, 16'hFFF0, 0, 0, 0);
        chk("R3 wrap", addr_log0, 32'hFFFF_FFF8);
    endtask

    task automatic t_index();
        run_op(4'd4, 32'hFFFF_FFF0, 32'h0000_0020, 0, 2'd3, 0, 0);
        chk("R4 bidx ignores scale", addr_log0, 32'h0000_0010);
        for (int s = 0; s < 4; s++) begin
            run_op(4'd5, 32'h0001_0000, 32'h0000_0013, 0, 2'(s), 0, 0);
            chk("R4 scaled addr", addr_log0, 32'h0001_0000 + (32'h13 << s));
        end
    endtask

    task automatic t_step();
        run_op(4'd6, 32'h0000_2000, 0, 16'h0700, 2'd2, 0, 0);
        chk("R5 postinc addr", addr_log0, 32'h0000_2000);
        chk("R5 postinc wb", r_wbd, 32'h0000_2004);
        chk("R9 postinc wb_en", {31'b0, r_wbe}, 32'd1);
        run_op(4'd7, 32'h0000_0002, 0, 0, 2'd3, 0, 0);
        chk("R5 postdec addr", addr_log0, 32'h0000_0002);
        chk("R5 postdec wb wrap", r_wbd, 32'hFFFF_FFFA);
        chk("R9 postdec wb_en", {31'b0, r_wbe}, 32'd1);
        run_op(4'd8, 32'h0000_3000, 0, 16'h0010, 0, 0, 0);
        chk("R6 update addr", addr_log0, 32'h0000_3010);
        chk("R6 update wb", r_wbd, 32'h0000_3010);
        chk("R6 update operand", r_opnd, scram(32'h0000_3010));
        chk("R9 update wb_en", {31'b0, r_wbe}, 32'd1);
        run_op(4'd4, 32'h0000_3000, 32'h4, 0, 0, 0, 0);
        chk("R9 bidx no wb", {31'b0, r_wbe}, 32'd0);
    endtask

    task automatic t_indirect();
        run_op(4'd9, 32'h0000_5000, 0, 16'h0004, 0, 0, 0);
        chk("R7 first addr", addr_log0, 32'h0000_5000);
        chk("R7 second addr", addr_log1, scram(32'h0000_5000));
        chk("R7 operand", r_opnd, scram(scram(32'h0000_5000)));
        chk("R7 two reads", req_cnt, 2);
        chk("R8 indirect latency", r_lat, 3);
        chk("R9 indirect no wb", {31'b0, r_wbe}, 32'd0);
    endtask

    task automatic t_illegal();
        for (int c = 10; c < 16; c += 5) begin
            run_op(4'(c), 32'h0000_6000, 0, 0, 0, 0, 0);
            chk("R10 illegal flag", {31'b0, r_ill}, 32'd1);
            chk("R10 illegal latency", r_lat, 1);
            chk("R10 no read", req_cnt, 0);
            chk("R10 no wb", {31'b0, r_wbe}, 32'd0);
        end
        @(negedge clk);
        chk("R10 flag one cycle", {31'b0, illegal}, 32'd0);
    endtask

    task automatic t_busy();
        int dones = 0;
        logic [31:0] got = '0;
        @(negedge clk);
        req_cnt = 0;
        mode = 4'd9; base_val = 32'h0000_7000; start = 1'b1;
        @(negedge clk);
        mode = 4'd0; disp = 16'h1234; base_val = 32'h0000_9000;
        @(negedge clk);
        mode = 4'd10;
        if (done) begin dones++; got = operand; end
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (done) begin dones++; got = operand; end
            @(negedge clk);
        end
        chk("R11 one done", dones, 1);
        chk("R11 result intact", got, scram(scram(32'h0000_7000)));
        chk("R11 no extra read", req_cnt, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_disp();
        t_index();
        t_step();
        t_indirect();
        t_illegal();
        t_busy();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule